// File: doc/BRIEF.md
# Serial Audio Receiver with Word Buffer

This block takes in a serial audio bit stream and turns it into parallel words. The bit clock and frame sync reach it as single-cycle enable pulses in the system clock domain. A frame sync seen on a bit-clock falling-edge pulse arms the receiver. The next `W` falling-edge pulses each sample one data bit, most significant bit first, into a shift register. When the last bit arrives, the finished word is handed on one clock later.

The finished word goes one of two ways, chosen by a mode input. In buffer mode it enters a small circular store of `DEPTH` entries, which software drains with a read strobe. Full and empty are told apart by remembering whether the last pointer-moving access was a write or a read. A word that arrives while the store is full is dropped and sets a sticky overrun flag. The flag holds the interrupt low until software clears it with a write-one-to-clear strobe. Reading an empty store is not blocked. In direct-transfer mode the word lands in a single holding register, and a transfer request stays raised until that register is read. A newer word simply replaces an unread one.

Top module: `audio_rx`

## Requirements
- R1: Serial data is sampled only on cycles where `bclk_fall` is high. The frame sync is taken on such a cycle, and the `W` pulses that follow form one word, with the first bit sampled as the word's most significant bit. `fsync` is sampled only on `bclk_fall` cycles.
- R2: In buffer mode (`mode_dma`=0), each finished word is stored at the write pointer and the pointer then advances. Every `rd_stb` returns `rd_data` from the read pointer in the same cycle and then advances that pointer, so words come out in arrival order.
- R3: The store is full when the pointers are equal and the last access was a write. A word finishing while the store is full is discarded, the write pointer stays put, and `ovr_flag` is set.
- R4: `irq` is high exactly when `irq_en` is 1, the block is in buffer mode, the store is not empty and `ovr_flag` is 0.
- R5: A read of an empty store is not blocked and does not set `ovr_flag`. The read pointer still advances, so afterwards the store no longer reads as empty.
- R6: In direct-transfer mode (`mode_dma`=1), a finished word is copied to the holding register, and `dma_req` is high while that register is unread. `rd_data` shows the register. A newer word overwrites an unread one, and `rd_stb` clears `dma_req`.
- R7: A frame sync that arrives mid-word restarts the word and drops the partial bits. `bclk_fall` pulses with no frame armed store nothing.
- R8: After reset, `irq`, `dma_req` and `ovr_flag` are 0 and the store is empty.
- R9: `ovr_flag` stays set until an `ovr_clr` pulse clears it. If a new overrun happens in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_fall | input | 1 | One-cycle pulse marking a bit-clock falling edge |
| fsync | input | 1 | Frame sync level, sampled on `bclk_fall` cycles |
| sdata | input | 1 | Serial data, sampled on `bclk_fall` cycles |
| mode_dma | input | 1 | 0 = buffer mode, 1 = direct-transfer mode |
| rd_stb | input | 1 | Read strobe for the receive data register |
| rd_data | output | W | Receive data: store head or holding register |
| ovr_clr | input | 1 | Write-one-to-clear pulse for the overrun flag |
| irq_en | input | 1 | Receive interrupt enable |
| irq | output | 1 | Receive interrupt |
| dma_req | output | 1 | Transfer request: holding register has an unread word |
| ovr_flag | output | 1 | Sticky buffer overrun flag |

## Verification
The bench fills the store to every level from one to `DEPTH` with computed patterns, reading each level back across pointer wrap. A design that used bare pointer equality would report a full store as empty and return nothing. It pushes one word past full and expects the first `DEPTH` words intact, the flag set and the interrupt held low. A design that wrote the extra word or moved the pointer would return the newest word in place of the oldest. It also checks that a restart mid-word yields only the complete word, that an empty read moves the pointer without raising the flag, and that direct-transfer mode overwrites an unread word without touching the store.

// File: rtl/audio_rx_pkg.sv
// Package: shared constants and types for the serial audio receiver.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package audio_rx_pkg;
    // Where a finished word is delivered.
    typedef enum logic {
        RX_TO_BUFFER = 1'b0,
        RX_TO_HOLD   = 1'b1
    } rx_path_e;

    localparam int unsigned RX_WORD_DEFAULT  = 16;
    localparam int unsigned RX_DEPTH_DEFAULT = 4;
endpackage

// File: rtl/audio_rx_shift.sv
// Module: deserialiser. Arms on a frame sync and then takes W bits,
// most significant first, on W bit-clock falling-edge pulses.
// Emits the word with a one-cycle done pulse, one clock after the last bit.
// Assumes: W >= 2. fsync and sdata are meaningful only when bclk_fall is high.
module audio_rx_shift #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bclk_fall,
    input  logic         fsync,
    input  logic         sdata,
    output logic         word_done,
    output logic [W-1:0] word_q
);
    localparam int unsigned CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

    logic          armed;
    logic [CW-1:0] bit_cnt;
    logic [W-1:0]  shreg;

    // Frame tracking, bit shifting and word hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            bit_cnt   <= '0;
            shreg     <= '0;
            word_done <= 1'b0;
            word_q    <= '0;
        end else begin
            word_done <= 1'b0;
            if (bclk_fall) begin
                if (fsync) begin
                    armed   <= 1'b1;
                    bit_cnt <= '0;
                end else if (armed) begin
                    shreg <= {shreg[W-2:0], sdata};
                    if (bit_cnt == LAST_BIT) begin
                        word_q    <= {shreg[W-2:0], sdata};
                        word_done <= 1'b1;
                        armed     <= 1'b0;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/audio_rx_ring.sv
// Module: circular word store. Full and empty are told apart by a flag
// recording whether the last pointer-moving access was a write.
// A push into a full store is refused and reported with a one-cycle pulse.
// A pop from an empty store is not blocked.
// Assumes: DEPTH is a power of two, so the pointers wrap naturally.
module audio_rx_ring #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty,
    output logic         refused
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          last_wr;
    logic          accept;

    assign full    = (wp == rp) && last_wr;
    assign empty   = (wp == rp) && !last_wr;
    assign accept  = push && !full;
    assign rdata   = mem[rp];

    // Storage array, written only when a push is accepted.
    always_ff @(posedge clk) begin
        if (accept) mem[wp] <= wdata;
    end

    // Pointer movement, last-access tracking and refusal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp      <= '0;
            rp      <= '0;
            last_wr <= 1'b0;
            refused <= 1'b0;
        end else begin
            refused <= push && full;
            if (accept) wp <= wp + 1'b1;
            if (pop)    rp <= rp + 1'b1;
            if (accept && !pop)      last_wr <= 1'b1;
            else if (pop && !accept) last_wr <= 1'b0;
        end
    end
endmodule

// File: rtl/audio_rx_hold.sv
// Module: single-word holding register for direct-transfer mode.
// A load overwrites the held word. The request stays high until a take.
// A load and a take in the same cycle leave the request high.
// Assumes: load and take are single-cycle strobes.
module audio_rx_hold #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] wdata,
    input  logic         take,
    output logic [W-1:0] hold_q,
    output logic         req
);
    // Holding register and its request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            req    <= 1'b0;
        end else begin
            if (load) begin
                hold_q <= wdata;
                req    <= 1'b1;
            end else if (take) begin
                req <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/audio_rx.sv
// Module: serial audio receiver top. Deserialises words and delivers them
// either to a circular store (buffer mode) or to a holding register with a
// transfer request (direct-transfer mode). Keeps a sticky overrun flag and
// drives the receive interrupt.
// Assumes: bclk_fall is a synchronous one-cycle enable. rd_stb and ovr_clr
// are one-cycle strobes from a register decoder.
module audio_rx
    import audio_rx_pkg::*;
#(
    parameter int unsigned W     = RX_WORD_DEFAULT,
    parameter int unsigned DEPTH = RX_DEPTH_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bclk_fall,
    input  logic         fsync,
    input  logic         sdata,
    input  logic         mode_dma,
    input  logic         rd_stb,
    output logic [W-1:0] rd_data,
    input  logic         ovr_clr,
    input  logic         irq_en,
    output logic         irq,
    output logic         dma_req,
    output logic         ovr_flag
);
    rx_path_e     path;
    logic         word_done;
    logic [W-1:0] word_q;
    logic [W-1:0] ring_rdata, hold_q;
    logic         ring_full, ring_empty, ring_refused;
    logic         to_ring, to_hold;

    assign path    = rx_path_e'(mode_dma);
    assign to_ring = (path == RX_TO_BUFFER);
    assign to_hold = (path == RX_TO_HOLD);

    audio_rx_shift #(.W(W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_fall (bclk_fall),
        .fsync     (fsync),
        .sdata     (sdata),
        .word_done (word_done),
        .word_q    (word_q)
    );

    audio_rx_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (word_done && to_ring),
        .wdata   (word_q),
        .pop     (rd_stb && to_ring),
        .rdata   (ring_rdata),
        .full    (ring_full),
        .empty   (ring_empty),
        .refused (ring_refused)
    );

    audio_rx_hold #(.W(W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (word_done && to_hold),
        .wdata  (word_q),
        .take   (rd_stb && to_hold),
        .hold_q (hold_q),
        .req    (dma_req)
    );

    // Sticky overrun flag: a new overrun wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)            ovr_flag <= 1'b0;
        else if (ring_refused) ovr_flag <= 1'b1;
        else if (ovr_clr)      ovr_flag <= 1'b0;
    end

    assign rd_data = to_hold ? hold_q : ring_rdata;
    assign irq     = irq_en && to_ring && !ring_empty && !ovr_flag;
endmodule

// File: rtl/audio_rx_chk.sv
// Module: property checker for audio_rx, attached with bind below.
// Assumes: it observes the top's ports and internal handshake nets only.
module audio_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_dma,
    input logic rd_stb,
    input logic ovr_clr,
    input logic irq,
    input logic dma_req,
    input logic ovr_flag,
    input logic word_done,
    input logic ring_full
);
    // R9: the flag holds unless cleared
    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag && !ovr_clr |=> ovr_flag);

    // R3: a word finishing into a full store raises the overrun flag
    a_r3_ovr_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        word_done && !mode_dma && ring_full |=> ##1 ovr_flag);

    // R3: a refused word leaves the store full
    a_r3_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
        word_done && !mode_dma && ring_full && !rd_stb |=> ring_full);

    // R4: no interrupt while an overrun is pending
    a_r4_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag |-> !irq);

    // R6: a finished word in direct-transfer mode raises the request
    a_r6_req_set: assert property (@(posedge clk) disable iff (!rst_n)
        word_done && mode_dma |=> dma_req);

    // R6: reading the holding register drops the request
    a_r6_req_clr: assert property (@(posedge clk) disable iff (!rst_n)
        mode_dma && rd_stb && !word_done |=> !dma_req);

    // R5: reads alone never raise the overrun flag
    a_r5_read_no_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_flag && !word_done && $past(!word_done) |=> !ovr_flag);
endmodule

bind audio_rx audio_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_dma  (mode_dma),
    .rd_stb    (rd_stb),
    .ovr_clr   (ovr_clr),
    .irq       (irq),
    .dma_req   (dma_req),
    .ovr_flag  (ovr_flag),
    .word_done (word_done),
    .ring_full (ring_full)
);

// File: tb/tb_audio_rx.sv
module tb_audio_rx;
    localparam int W     = 16;
    localparam int DEPTH = 4;

    logic         clk = 1'b0;
    logic         rst_n, bclk_fall, fsync, sdata, mode_dma, rd_stb;
    logic         ovr_clr, irq_en, irq, dma_req, ovr_flag;
    logic [W-1:0] rd_data;
    int           checks = 0;
    int           errors = 0;

    always #10 clk = ~clk;

    audio_rx #(.W(W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .bclk_fall(bclk_fall), .fsync(fsync),
        .sdata(sdata), .mode_dma(mode_dma), .rd_stb(rd_stb),
        .rd_data(rd_data), .ovr_clr(ovr_clr), .irq_en(irq_en), .irq(irq),
        .dma_req(dma_req), .ovr_flag(ovr_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int a, input int b);
        return W'((a * 16'h3B17) ^ (b * 16'h0A5D) ^ 16'hC6A1);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bclk_fall = 0; fsync = 0; sdata = 0; rd_stb = 0;
        ovr_clr = 0; mode_dma = 0; irq_en = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bit_pulse(input logic fs, input logic d);
        @(negedge clk); bclk_fall = 1; fsync = fs; sdata = d;
        @(negedge clk); bclk_fall = 0; fsync = 0;
    endtask

    task automatic send_word(input logic [W-1:0] v);
        bit_pulse(1'b1, 1'b0);
        for (int i = W - 1; i >= 0; i--) bit_pulse(1'b0, v[i]);
        repeat (2) @(negedge clk);
    endtask

    task automatic read_expect(input string req, input logic [W-1:0] exp);
        @(negedge clk);
        chk(req, 32'(rd_data), 32'(exp));
        rd_stb = 1;
        @(negedge clk); rd_stb = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R8 reset state
        chk("R8 irq", 32'(irq), 0);
        chk("R8 dma_req", 32'(dma_req), 0);
        chk("R8 ovr_flag", 32'(ovr_flag), 0);

        // R1 R2: every fill level, pointers wrapping across rounds
        for (int rnd = 0; rnd < 3; rnd++) begin
            for (int n = 1; n <= DEPTH; n++) begin
                for (int i = 0; i < n; i++) send_word(pat(rnd * 8 + n, i));
                chk("R4 irq with data", 32'(irq), 1);
                for (int i = 0; i < n; i++) read_expect("R2 order/R1 msb first", pat(rnd * 8 + n, i));
                chk("R4 irq empty", 32'(irq), 0);
            end
        end

        // R1 edge patterns
        send_word('0);   read_expect("R1 zeros", '0);
        send_word('1);   read_expect("R1 ones", '1);
        send_word(W'(1) << (W - 1)); read_expect("R1 msb only", W'(1) << (W - 1));
        send_word(W'(1)); read_expect("R1 lsb only", W'(1));

        // R4 enable gating
        send_word(pat(50, 0));
        @(negedge clk); irq_en = 0;
        @(negedge clk); chk("R4 irq disabled", 32'(irq), 0);
        irq_en = 1;
        @(negedge clk); chk("R4 irq re-enabled", 32'(irq), 1);
        read_expect("R2 single", pat(50, 0));

        // R3 R9 overrun
        for (int i = 0; i < DEPTH; i++) send_word(pat(60, i));
        chk("R3 no ovr at full", 32'(ovr_flag), 0);
        send_word(pat(60, 9));
        chk("R3 ovr set", 32'(ovr_flag), 1);
        chk("R4 irq held low on ovr", 32'(irq), 0);
        repeat (5) @(negedge clk);
        chk("R9 sticky", 32'(ovr_flag), 1);
        ovr_clr = 1; @(negedge clk); ovr_clr = 0;
        @(negedge clk);
        chk("R9 cleared", 32'(ovr_flag), 0);
        chk("R4 irq back", 32'(irq), 1);
        for (int i = 0; i < DEPTH; i++) read_expect("R3 dropped word not stored", pat(60, i));
        chk("R3 empty after drain", 32'(irq), 0);

        // R7 restart mid-word, then stray pulses
        bit_pulse(1'b1, 1'b0);
        for (int i = 0; i < 5; i++) bit_pulse(1'b0, 1'b1);
        send_word(pat(70, 1));
        read_expect("R7 restart", pat(70, 1));
        chk("R7 one word only", 32'(irq), 0);
        for (int i = 0; i < 3 * W; i++) bit_pulse(1'b0, 1'b1);
        repeat (2) @(negedge clk);
        chk("R7 unframed bits ignored", 32'(irq), 0);

        // R5 underrun
        @(negedge clk); rd_stb = 1; @(negedge clk); rd_stb = 0;
        @(negedge clk);
        chk("R5 no ovr on underrun", 32'(ovr_flag), 0);
        chk("R5 pointer moved", 32'(irq), 1);

        // R6 direct-transfer mode
        do_reset();
        mode_dma = 1;
        send_word(pat(80, 0));
        chk("R6 req set", 32'(dma_req), 1);
        chk("R6 data", 32'(rd_data), 32'(pat(80, 0)));
        chk("R4 no irq in hold mode", 32'(irq), 0);
        send_word(pat(80, 1));
        chk("R6 overwrite", 32'(rd_data), 32'(pat(80, 1)));
        chk("R6 no ovr", 32'(ovr_flag), 0);
        read_expect("R6 read", pat(80, 1));
        chk("R6 req cleared", 32'(dma_req), 0);
        @(negedge clk); mode_dma = 0;
        @(negedge clk);
        chk("R6 store untouched", 32'(irq), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule